// File: doc/BRIEF.md
# Serial CRC-4 Encoder and Checker

This block computes a 4-bit cyclic redundancy code one bit per clock, using long division over GF(2) by the generator x^4+x+1. The remainder register holds the running remainder of everything shifted in since the last start pulse. Each step shifts the register left by one and takes the new bit into the low end. If the bit shifted out of the top was 1, the result is XORed with the low part of the divisor, 0011.

The block has two modes. In encode mode, the caller presents the message bits. After the bit flagged as last, the block feeds four zero bits into the divider on its own. The final remainder is the check code that the sender appends to the message. In check mode, the caller presents a received frame, which is the message followed by its 4-bit code. The block reports an error when the remainder at the end of the frame is not zero.

Each frame begins with a start pulse, which clears the block and samples the mode. The frame ends with a one-cycle done strobe. The remainder and the error flag then hold until the next start pulse.

Top module: `crc4_serial_codec`

## Requirements
- R1: For each consumed bit b, the remainder becomes {rem[2:0], b}, XORed with 4'b0011 when rem[3] was 1. The remainder output shows the register after every step.
- R2: After reset, rem_o is 0, done_o is 0 and err_o is 0. The block is idle and ignores bit_vld_i until a start pulse arrives.
- R3: A start_i pulse clears the remainder, err_o, done_o and the padding counter in that cycle. It samples mode_i (0 = encode, 1 = check). Any bit presented in the same cycle is not consumed.
- R4: In encode mode, the block consumes the valid bit marked by last_i. It then shifts exactly four zero bits on the next four clocks, and ignores bit_vld_i and bit_i during those clocks.
- R5: In encode mode, the 12-bit message 100100011100 (first bit on the left) produces the check code 4'b1100.
- R6: In check mode, err_o rises with done_o exactly when the final remainder is non-zero. In encode mode, err_o stays 0.
- R7: done_o is high for exactly one clock. In check mode, it is high in the cycle after the last valid bit. In encode mode, it is high in the cycle after the fourth padding bit. The final rem_o and err_o are valid in that same cycle.
- R8: After done_o, rem_o and err_o hold their values and bit_vld_i is ignored until the next start pulse.
- R9: A cycle with bit_vld_i low changes nothing. last_i has no effect unless bit_vld_i is also high.
- R10: A start pulse while a frame is in progress, including during padding, abandons that frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears the block, starts a frame and samples the mode |
| bit_vld_i | input | 1 | bit_i is valid in this cycle |
| bit_i | input | 1 | Serial data bit, most significant first |
| last_i | input | 1 | Marks the final valid bit of the frame |
| mode_i | input | 1 | 0 = encode, 1 = check; sampled with start_i |
| rem_o | output | 4 | Remainder register |
| done_o | output | 1 | One-cycle strobe at the end of a frame |
| err_o | output | 1 | Check mode: the final remainder is non-zero |

## Verification
The known 12-bit message is run through encode mode to pin down the divisor and the shift direction. Its coded frame is then run through check mode, once intact and once with a flipped bit, which separates a zero from a non-zero final remainder. Gapped valid strobes, a lone last marker and noise on the inputs during padding show whether stalls and ignored inputs change the result. Idle bits after done, and restarts both mid-message and mid-padding, show whether results hold and whether a frame is abandoned cleanly. Messages of random length 1 to 16 are encoded and then re-checked, both intact and with one bit corrupted, against a behavioural division model that is compared on every clock.

// File: rtl/crc4_pkg.sv
package crc4_pkg;
  localparam int CRC_W = 4;
  // Low part of the divisor 1_0011; the leading 1 is implied by the shift-out.
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_FEED = 2'd1,
    SEQ_PAD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/crc_div_step.sv
module crc_div_step #(
  parameter int          W    = 4,
  parameter logic [W-1:0] POLY = 4'b0011
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = cur[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt[0] = din ^ (fb & POLY[0]);
    end else begin : g_upper
      assign nxt[i] = cur[i-1] ^ (fb & POLY[i]);
    end
  end
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import crc4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic last,
  input  logic mode,
  output logic shift_en,
  output logic shift_bit,
  output logic fin,
  output logic chk_mode,
  output logic busy,
  output logic padding
);
  localparam int CNTW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNTW-1:0] PAD_LAST = CNTW'(W - 1);

  seq_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            mode_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    shift_en  = 1'b0;
    shift_bit = 1'b0;
    fin       = 1'b0;
    if (start) begin
      state_d = SEQ_FEED;
      cnt_d   = '0;
    end else begin
      case (state_q)
        SEQ_FEED: begin
          if (bit_vld) begin
            shift_en  = 1'b1;
            shift_bit = bit_in;
            if (last) begin
              cnt_d = '0;
              if (mode_q) begin
                fin     = 1'b1;
                state_d = SEQ_IDLE;
              end else begin
                state_d = SEQ_PAD;
              end
            end
          end
        end
        SEQ_PAD: begin
          shift_en  = 1'b1;
          shift_bit = 1'b0;
          if (cnt_q == PAD_LAST) begin
            fin     = 1'b1;
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (start) mode_q <= mode;
    end
  end

  assign chk_mode = mode_q;
  assign busy     = (state_q != SEQ_IDLE);
  assign padding  = (state_q == SEQ_PAD);
endmodule

// File: rtl/crc_rem_reg.sv
module crc_rem_reg #(
  parameter int           W    = 4,
  parameter logic [W-1:0] POLY = 4'b0011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         fin,
  input  logic         chk_mode,
  output logic [W-1:0] rem,
  output logic         done,
  output logic         err
);
  logic [W-1:0] nxt;

  crc_div_step #(.W(W), .POLY(POLY)) u_step (
    .cur (rem),
    .din (shift_bit),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= fin;
      if (shift_en) rem <= nxt;
      if (fin)      err <= chk_mode && (nxt != '0);
    end
  end
endmodule

// File: rtl/crc4_serial_codec.sv
module crc4_serial_codec
  import crc4_pkg::*;
#(
  parameter int           W    = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  input  logic         last_i,
  input  logic         mode_i,
  output logic [W-1:0] rem_o,
  output logic         done_o,
  output logic         err_o
);
  logic shift_en, shift_bit, fin, chk_mode;
  logic busy_w, pad_w;

  crc_seq_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .bit_vld   (bit_vld_i),
    .bit_in    (bit_i),
    .last      (last_i),
    .mode      (mode_i),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .fin       (fin),
    .chk_mode  (chk_mode),
    .busy      (busy_w),
    .padding   (pad_w)
  );

  crc_rem_reg #(.W(W), .POLY(POLY)) u_rem (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_i),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .fin       (fin),
    .chk_mode  (chk_mode),
    .rem       (rem_o),
    .done      (done_o),
    .err       (err_o)
  );
endmodule

// File: rtl/crc4_serial_codec_chk.sv
module crc4_serial_codec_chk #(
  parameter int W = crc4_pkg::CRC_W
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [W-1:0] rem_o,
  input logic         done_o,
  input logic         err_o,
  input logic         busy,
  input logic         padding
);
  int pad_run;

  always_ff @(posedge clk) begin
    if (rst || !padding || start_i) pad_run <= 0;
    else                            pad_run <= pad_run + 1;
  end

  // R3: a start pulse leaves the block cleared on the next cycle
  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (rem_o == '0) && !done_o && !err_o);

  // R7: the done strobe lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6: the error flag is reported only with a non-zero remainder
  a_r6_err_nonzero: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (rem_o != '0));

  // R6: the error flag rises only together with done
  a_r6_err_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);

  // R8: with no frame running and no start, the results hold
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_i) |=> ($stable(rem_o) && $stable(err_o)));

  // R4: padding never stalls; it continues or finishes
  a_r4_pad_progress: assert property (@(posedge clk) disable iff (rst)
    (padding && !start_i) |=> (padding || done_o));

  // R4: padding never runs beyond W cycles
  a_r4_pad_len: assert property (@(posedge clk) disable iff (rst)
    padding |-> (pad_run < W));
endmodule

bind crc4_serial_codec crc4_serial_codec_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .rem_o   (rem_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .busy    (busy_w),
  .padding (pad_w)
);

// File: tb/crc4_serial_codec_bench.sv
module crc4_serial_codec_bench;
  typedef bit bq_t[$];

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, vld = 1'b0, bin = 1'b0, last = 1'b0, mode = 1'b0;
  logic [3:0] rem;
  logic done, err;

  always #10 clk = ~clk;

  crc4_serial_codec u_crc4_serial_codec (
    .clk (clk), .rst (rst), .start_i (start), .bit_vld_i (vld),
    .bit_i (bin), .last_i (last), .mode_i (mode),
    .rem_o (rem), .done_o (done), .err_o (err)
  );

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  // Reference: remainder of the bit string modulo 1_0011 by long division
  function automatic int poly_mod(input bq_t q);
    int r = 0;
    foreach (q[i]) begin
      r = (r << 1) | int'(q[i]);
      if ((r & 16) != 0) r = r ^ 19;
    end
    return r;
  endfunction

  function automatic bq_t mk_q(input logic [31:0] val, input int len);
    bq_t q;
    for (int i = len - 1; i >= 0; i--) q.push_back(val[i]);
    return q;
  endfunction

  // Behavioural cycle model
  bq_t mq;
  int  m_rem = 0, m_pad = 0;
  bit  m_done = 0, m_err = 0, m_busy = 0, m_mode = 0;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_rem = 0; m_done = 0; m_err = 0; m_busy = 0; m_pad = 0; m_mode = 0;
    end else if (start) begin
      mq.delete(); m_rem = 0; m_done = 0; m_err = 0; m_busy = 1; m_pad = 0; m_mode = mode;
    end else begin
      m_done = 0;
      if (m_pad > 0) begin
        mq.push_back(1'b0);
        m_rem = poly_mod(mq);
        m_pad--;
        if (m_pad == 0) begin m_done = 1; m_busy = 0; m_err = 0; end
      end else if (m_busy && vld) begin
        mq.push_back(bin);
        m_rem = poly_mod(mq);
        if (last) begin
          if (m_mode) begin m_done = 1; m_busy = 0; m_err = (m_rem != 0); end
          else m_pad = 4;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 remainder per cycle", int'(rem), m_rem);
      chk("R7 done per cycle", int'(done), int'(m_done));
      chk("R6 err per cycle", int'(err), int'(m_err));
    end
  end

  task automatic step(input bit s, input bit v, input bit b, input bit l);
    start = s; vld = v; bin = b; last = l;
    @(negedge clk);
  endtask

  // Start pulse carries a valid 1 bit that must be dropped (R3)
  task automatic send(input logic [31:0] val, input int len, input bit m);
    mode = m;
    step(1, 1, 1, 1);
    for (int i = len - 1; i >= 0; i--) step(0, 1, val[i], i == 0);
    vld = 0; last = 0;
  endtask

  task automatic wait_done(input bit noise);
    for (int i = 0; i < 8; i++) begin
      if (done) break;
      step(0, noise, noise, noise);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] msg, frame;
    int len, code, k;
    bq_t q;

    @(negedge clk); cmp_on = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R2 reset rem", int'(rem), 0);
    chk("R2 reset done", int'(done), 0);
    chk("R2 reset err", int'(err), 0);
    step(0, 1, 1, 0); step(0, 1, 1, 0); step(0, 1, 1, 1);
    chk("R2 idle ignores bits", int'(rem), 0);
    chk("R2 idle no done", int'(done), 0);

    // Known example, noisy inputs during padding
    send(32'h91C, 12, 0);
    wait_done(1);
    chk("R5 example code", int'(rem), 'hC);
    chk("R7 done with code", int'(done), 1);
    chk("R6 encode err low", int'(err), 0);
    step(0, 0, 0, 0);
    chk("R7 done drops", int'(done), 0);
    step(0, 1, 1, 0); step(0, 1, 0, 1); step(0, 1, 1, 1);
    chk("R8 code holds", int'(rem), 'hC);

    // Check mode: intact frame, then corrupted
    send(32'h91CC, 16, 1);
    chk("R7 done after last check bit", int'(done), 1);
    chk("R6 intact frame err", int'(err), 0);
    chk("R6 intact frame rem", int'(rem), 0);
    send(32'h91CC ^ 32'h20, 16, 1);
    chk("R6 corrupted frame err", int'(err), 1);
    chk("R6 corrupted frame rem", int'(rem), poly_mod(mk_q(32'h91CC ^ 32'h20, 16)));
    step(0, 1, 0, 1); step(0, 1, 1, 0);
    chk("R8 err holds", int'(err), 1);

    // Stalls and lone last markers
    mode = 0; step(1, 0, 0, 0);
    for (int i = 11; i >= 0; i--) begin
      step(0, 0, 1, 1);
      step(0, 1, msg_bit(32'h91C, i), i == 0);
    end
    vld = 0; last = 0;
    wait_done(0);
    chk("R9 stalled encode code", int'(rem), 'hC);

    // Abort mid-message, and abort mid-padding
    mode = 0; step(1, 0, 0, 0);
    step(0, 1, 1, 0); step(0, 1, 0, 0); step(0, 1, 1, 0);
    send(32'h91C, 12, 0);
    wait_done(0);
    chk("R10 restart mid-message", int'(rem), 'hC);
    send(32'h5, 3, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    send(32'h91CC, 16, 1);
    chk("R10 restart mid-padding err", int'(err), 0);
    chk("R10 restart mid-padding done", int'(done), 1);

    // Random messages: encode, re-check, corrupt
    for (int n = 0; n < 40; n++) begin
      len = $urandom_range(1, 16);
      msg = $urandom() & ((32'h1 << len) - 1);
      send(msg, len, 0);
      wait_done(n[0]);
      q = mk_q(msg << 4, len + 4);
      code = int'(rem);
      chk("R1 random code", code, poly_mod(q));
      frame = (msg << 4) | 32'(code);
      send(frame, len + 4, 1);
      chk("R6 random intact", int'(err), 0);
      k = $urandom_range(0, len + 3);
      send(frame ^ (32'h1 << k), len + 4, 1);
      chk("R6 random single-bit error", int'(err), 1);
    end

    step(0, 0, 0, 0);
    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic bit msg_bit(input logic [31:0] v, input int i);
    return v[i];
  endfunction
endmodule